// File: doc/BRIEF.md
# Regulator Fault Counter Supervisor

This block watches the fault flags of a group of power regulators and decides, clock by clock, what happens to each of them. An undervoltage or overcurrent flag switches off only the regulator that raised it. A regulator that is powered from a switched-off regulator is treated as faulted one clock later. An overvoltage on one of the regulators chosen by a mask parameter stops everything at once. That stop is latched until the system passes through the deep-off state and back out of it.

Each fault event adds one to a fault counter. Several events in one clock each add one, and the counter saturates at the active limit. Once the counter reaches that limit, the block latches a global shutdown. The limit is lower while the system is coming back up from deep off, and higher at any other time. A quiet timer forgives earlier faults: after a long run of fault-free clocks it clears the counter. Between faults, a retry stepper brings switched-off regulators back one at a time. It works in ascending index order and raises a one-clock start request for each one, which the power sequencer uses to soft-start it. Regulators that are running are never touched.

Top module: `fsup_supervisor`

## Requirements
- R1: A synchronous active-high `rst` clears the fault counter, the quiet timer, the retry timer, all `fault_dis` bits, `restart_req` and the `shutdown` latch. All three outputs read 0 after the reset edge.
- R2: An undervoltage (`uv_flag[k]`) or overcurrent (`oc_flag[k]`) flag on an enabled regulator k sets `fault_dis[k]` at the next clock edge. All other bits stay as they were and `shutdown` is not set, unless the count limit of R6 is reached.
- R3: An `ov_flag[k]` with bit k set in `OV_MASK` (default: bits 0 and 1) sets `shutdown` at the next clock edge. An `ov_flag` on a regulator outside the mask has no effect.
- R4: `shutdown` stays set until `slp_s5` is sampled low and is then sampled high. At that rising sample, `shutdown` and every `fault_dis` bit clear. While `shutdown` is set, undervoltage and overcurrent flags neither disable regulators nor count.
- R5: Bit `j*N_REG+i` of `dep_map` marks regulator j as fed by regulator i. An enabled regulator with any disabled feeder gets its own `fault_dis` bit one edge later. That cascade fault counts as one fault.
- R6: Each fault event adds 1 to the fault counter, including several events in one clock. `shutdown` sets at the edge where the count reaches `TRIP_RESTART` (default 4) while `restart_s5` is 1, or `TRIP_NORMAL` (default 5) while it is 0.
- R7: The counter returns to 0 after `QUIET_CLKS` (default 16384) consecutive fault-free edges. A fault preceded by only `QUIET_CLKS-1` fault-free edges still adds to the old count.
- R8: This requirement applies while `shutdown` is 0 and some `fault_dis` bit is set. After `STEP_CLKS` (default 2048) edges with no fault event, the lowest-index disabled regulator is re-enabled. `restart_req` shows its one-hot bit for that one clock, and the stepper repeats for the next disabled regulator. A fault event restarts the interval.
- R9: A fault flag held on a regulator that is already disabled is ignored. It does not add to the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uv_flag | input | N_REG | Undervoltage flag per regulator |
| ov_flag | input | N_REG | Overvoltage flag per regulator |
| oc_flag | input | N_REG | Overcurrent flag per regulator |
| dep_map | input | N_REG*N_REG | Bit j*N_REG+i set: regulator j is fed by regulator i |
| restart_s5 | input | 1 | 1 while the system is coming up from deep off |
| slp_s5 | input | 1 | Low in deep off, high otherwise |
| fault_dis | output | N_REG | Regulator switched off by a fault |
| shutdown | output | 1 | Latched global shutdown |
| restart_req | output | N_REG | One-hot, one-clock soft-start request |

## Verification
Two events can land on the same clock edge: the quiet timer reaching its forgiveness point, and a new fault event. The bench forces this. It takes the counter to one below the normal limit, then places the next fault exactly `QUIET_CLKS` edges after the previous one, so only `QUIET_CLKS-1` fault-free edges come before it. A correct design counts that fault and shuts down. A second run moves the fault one edge later. There the count has already cleared, so `shutdown` must stay low.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
   // bit width able to hold the value v (at least one bit)
   function automatic int unsigned width_for(input int unsigned v);
      int unsigned w;
      w = 1;
      while ((64'd1 << w) <= 64'(v)) w++;
      return w;
   endfunction

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/fsup_event_gate.sv
module fsup_event_gate
   import fsup_pkg::*;
#(
   parameter int unsigned N_REG      = 4,
   parameter bit          CASCADE_EN = 1'b1,
   localparam int unsigned EW        = width_for(N_REG)
) (
   input  logic [N_REG-1:0]       dis_q,
   input  logic [N_REG-1:0]       uv_flag,
   input  logic [N_REG-1:0]       oc_flag,
   input  logic [N_REG*N_REG-1:0] dep_map,
   input  logic                   block,
   output logic [N_REG-1:0]       new_f,
   output logic [EW-1:0]          n_ev
);
   logic [N_REG-1:0] own_f;
   logic [N_REG-1:0] casc_f;

   assign own_f = (uv_flag | oc_flag) & ~dis_q;

   generate
      if (CASCADE_EN) begin : g_casc
         for (genvar j = 0; j < N_REG; j++) begin : g_dn
            logic feeder_off;
            assign feeder_off = |(dep_map[j*N_REG +: N_REG] & dis_q);
            assign casc_f[j]  = feeder_off & ~dis_q[j];
         end
      end else begin : g_nocasc
         logic unused_map;
         assign unused_map = ^dep_map;
         assign casc_f     = '0;
      end
   endgenerate

   assign new_f = (own_f | casc_f) & {N_REG{~block}};

   always_comb begin
      n_ev = '0;
      for (int k = 0; k < N_REG; k++) n_ev = n_ev + EW'(new_f[k]);
   end
endmodule

// File: rtl/fsup_tally.sv
module fsup_tally
   import fsup_pkg::*;
#(
   parameter int unsigned N_REG        = 4,
   parameter int unsigned TRIP_RESTART = 4,
   parameter int unsigned TRIP_NORMAL  = 5,
   parameter int unsigned QUIET_CLKS   = 16384,
   localparam int unsigned EW          = width_for(N_REG),
   localparam int unsigned TRIP_MAX    = max_of(TRIP_RESTART, TRIP_NORMAL),
   localparam int unsigned CW          = width_for(TRIP_MAX + N_REG),
   localparam int unsigned QW          = width_for(QUIET_CLKS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [EW-1:0] n_ev,
   input  logic          restart_s5,
   output logic          trip_hit
);
   logic [CW-1:0] cnt_q;
   logic [QW-1:0] quiet_q;
   logic [CW-1:0] sum;
   logic [CW-1:0] trip_v;
   logic          any_ev;

   assign any_ev   = (n_ev != '0);
   assign trip_v   = restart_s5 ? CW'(TRIP_RESTART) : CW'(TRIP_NORMAL);
   assign sum      = cnt_q + CW'(n_ev);
   assign trip_hit = any_ev && (sum >= trip_v);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         quiet_q <= QW'(QUIET_CLKS);
      end else if (any_ev) begin
         cnt_q   <= (sum >= trip_v) ? trip_v : sum;
         quiet_q <= '0;
      end else if (quiet_q == QW'(QUIET_CLKS - 1)) begin
         cnt_q   <= '0;
         quiet_q <= QW'(QUIET_CLKS);
      end else if (quiet_q < QW'(QUIET_CLKS)) begin
         quiet_q <= quiet_q + 1'b1;
      end
   end

   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CW'(TRIP_MAX));
   assert_quiet_bound_R7: assert property (@(posedge clk) disable iff (rst)
      quiet_q <= QW'(QUIET_CLKS));
   assert_forgive_R7: assert property (@(posedge clk) disable iff (rst)
      (quiet_q == QW'(QUIET_CLKS - 1) && !any_ev) |=> (cnt_q == '0));
   assert_event_rewinds_R7: assert property (@(posedge clk) disable iff (rst)
      any_ev |=> (quiet_q == '0));
endmodule

// File: rtl/fsup_retry.sv
module fsup_retry
   import fsup_pkg::*;
#(
   parameter int unsigned N_REG     = 4,
   parameter int unsigned STEP_CLKS = 2048,
   localparam int unsigned TW       = width_for(STEP_CLKS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_REG-1:0] dis_q,
   input  logic             idle,
   input  logic             fault_ev,
   output logic [N_REG-1:0] grant
);
   logic [TW-1:0]    t_q;
   logic             due;
   logic [N_REG:0]   seen;
   logic [N_REG-1:0] pick;

   assign due = (t_q == TW'(STEP_CLKS - 1)) && !idle && !fault_ev;

   always_ff @(posedge clk) begin
      if (rst || idle || fault_ev || due) t_q <= '0;
      else                                t_q <= t_q + 1'b1;
   end

   assign seen[0] = 1'b0;
   generate
      for (genvar k = 0; k < N_REG; k++) begin : g_pick
         assign pick[k]   = dis_q[k] & ~seen[k];
         assign seen[k+1] = seen[k] | dis_q[k];
      end
   endgenerate

   assign grant = due ? pick : '0;

   assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant));
   assert_timer_bound_R8: assert property (@(posedge clk) disable iff (rst)
      t_q < TW'(STEP_CLKS));
endmodule

// File: rtl/fsup_supervisor.sv
module fsup_supervisor
   import fsup_pkg::*;
#(
   parameter int unsigned N_REG        = 4,
   parameter logic [N_REG-1:0] OV_MASK = N_REG'(3),
   parameter int unsigned TRIP_RESTART = 4,
   parameter int unsigned TRIP_NORMAL  = 5,
   parameter int unsigned QUIET_CLKS   = 16384,
   parameter int unsigned STEP_CLKS    = 2048,
   parameter bit          CASCADE_EN   = 1'b1,
   localparam int unsigned EW          = width_for(N_REG)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [N_REG-1:0]       uv_flag,
   input  logic [N_REG-1:0]       ov_flag,
   input  logic [N_REG-1:0]       oc_flag,
   input  logic [N_REG*N_REG-1:0] dep_map,
   input  logic                   restart_s5,
   input  logic                   slp_s5,
   output logic [N_REG-1:0]       fault_dis,
   output logic                   shutdown,
   output logic [N_REG-1:0]       restart_req
);
   generate
      if (N_REG < 1 || N_REG > 32) begin : g_bad_n
         $error("fsup_supervisor: N_REG out of range");
      end
      if (TRIP_RESTART < 1 || TRIP_NORMAL < 1) begin : g_bad_trip
         $error("fsup_supervisor: trip limits must be at least 1");
      end
      if (QUIET_CLKS < 2 || STEP_CLKS < 2) begin : g_bad_time
         $error("fsup_supervisor: timer lengths must be at least 2");
      end
   endgenerate

   logic [N_REG-1:0] dis_q;
   logic [N_REG-1:0] req_q;
   logic             shut_q;
   logic             slp_q;
   logic             s5_exit;
   logic             ov_hit;
   logic             block;
   logic [N_REG-1:0] new_f;
   logic [EW-1:0]    n_ev;
   logic             trip_hit;
   logic [N_REG-1:0] grant;
   logic             retry_idle;

   assign s5_exit    = slp_s5 & ~slp_q;
   assign ov_hit     = |(ov_flag & OV_MASK);
   assign block      = shut_q | s5_exit;
   assign retry_idle = shut_q | s5_exit | ~(|dis_q);

   fsup_event_gate #(.N_REG(N_REG), .CASCADE_EN(CASCADE_EN)) i_gate (
      .dis_q(dis_q), .uv_flag(uv_flag), .oc_flag(oc_flag), .dep_map(dep_map),
      .block(block), .new_f(new_f), .n_ev(n_ev)
   );

   fsup_tally #(.N_REG(N_REG), .TRIP_RESTART(TRIP_RESTART), .TRIP_NORMAL(TRIP_NORMAL),
                .QUIET_CLKS(QUIET_CLKS)) i_tally (
      .clk(clk), .rst(rst), .n_ev(n_ev), .restart_s5(restart_s5), .trip_hit(trip_hit)
   );

   fsup_retry #(.N_REG(N_REG), .STEP_CLKS(STEP_CLKS)) i_retry (
      .clk(clk), .rst(rst), .dis_q(dis_q), .idle(retry_idle),
      .fault_ev(|new_f), .grant(grant)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         dis_q  <= '0;
         req_q  <= '0;
         shut_q <= 1'b0;
         slp_q  <= 1'b1;
      end else begin
         slp_q <= slp_s5;
         req_q <= grant;
         if (s5_exit) begin
            dis_q  <= '0;
            shut_q <= 1'b0;
         end else begin
            dis_q  <= (dis_q | new_f) & ~grant;
            shut_q <= shut_q | ov_hit | trip_hit;
         end
      end
   end

   assign fault_dis   = dis_q;
   assign shutdown    = shut_q;
   assign restart_req = req_q;

   assert_ov_stop_R3: assert property (@(posedge clk) disable iff (rst)
      (ov_hit && !s5_exit) |=> shutdown);
   assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (shutdown && !s5_exit) |=> shutdown);
   assert_frozen_in_stop_R4: assert property (@(posedge clk) disable iff (rst)
      (shutdown && !s5_exit) |=> $stable(fault_dis));
   assert_new_on_enabled_R9: assert property (@(posedge clk) disable iff (rst)
      (new_f & dis_q) == '0);
   assert_req_onehot_R8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(restart_req));

   generate
      for (genvar k = 0; k < N_REG; k++) begin : g_req_chk
         assert_req_reenables_R8: assert property (@(posedge clk) disable iff (rst)
            restart_req[k] |-> (!fault_dis[k] && $past(fault_dis[k])));
      end
   endgenerate
endmodule

// File: tb/test_fsup_supervisor.sv
`timescale 1ns/1ps
module test_fsup_supervisor;
   localparam int N = 4;
   localparam int QUIET = 16384;
   localparam int STEP = 2048;

   logic         clk = 1'b0;
   logic         rst;
   logic [N-1:0] uv_flag, ov_flag, oc_flag;
   logic [N*N-1:0] dep_map;
   logic         restart_s5, slp_s5;
   logic [N-1:0] fault_dis, restart_req;
   logic         shutdown;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fsup_supervisor i_fsup_supervisor (
      .clk(clk), .rst(rst), .uv_flag(uv_flag), .ov_flag(ov_flag), .oc_flag(oc_flag),
      .dep_map(dep_map), .restart_s5(restart_s5), .slp_s5(slp_s5),
      .fault_dis(fault_dis), .shutdown(shutdown), .restart_req(restart_req)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; uv_flag = '0; ov_flag = '0; oc_flag = '0;
      dep_map = '0; restart_s5 = 1'b0; slp_s5 = 1'b1;
      wait_n(2);
      rst = 1'b0;
   endtask

   // flags applied for exactly one sampling edge; returns just after it
   task automatic pulse(input logic [N-1:0] uvm, input logic [N-1:0] ovm,
                        input logic [N-1:0] ocm);
      uv_flag = uvm; ov_flag = ovm; oc_flag = ocm;
      @(negedge clk);
      uv_flag = '0; ov_flag = '0; oc_flag = '0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "fault_dis after reset", 32'(fault_dis), 0);
      chk("R1", "shutdown after reset", 32'(shutdown), 0);
      chk("R1", "restart_req after reset", 32'(restart_req), 0);
   endtask

   task automatic t_single();
      do_reset();
      pulse(4'b0010, 4'b0000, 4'b0000);
      chk("R2", "uv on reg1", 32'(fault_dis), 32'h2);
      chk("R2", "no shutdown", 32'(shutdown), 0);
      pulse(4'b0000, 4'b0000, 4'b1000);
      chk("R2", "oc on reg3", 32'(fault_dis), 32'ha);
   endtask

   task automatic t_ov_and_s5();
      do_reset();
      pulse(4'b0000, 4'b1000, 4'b0000);
      chk("R3", "ov outside mask ignored", 32'(shutdown), 0);
      chk("R3", "ov outside mask no disable", 32'(fault_dis), 0);
      pulse(4'b0000, 4'b0010, 4'b0000);
      chk("R3", "ov on reg1 stops", 32'(shutdown), 1);
      pulse(4'b0100, 4'b0000, 4'b0000);
      chk("R4", "uv ignored in shutdown", 32'(fault_dis), 0);
      slp_s5 = 1'b0;
      wait_n(3);
      chk("R4", "latched while in deep off", 32'(shutdown), 1);
      slp_s5 = 1'b1;
      wait_n(1);
      chk("R4", "cleared on exit", 32'(shutdown), 0);
      pulse(4'b0000, 4'b0001, 4'b0000);
      chk("R3", "ov on reg0 stops", 32'(shutdown), 1);
      // a fresh reset also clears the latch
      rst = 1'b1; wait_n(1); rst = 1'b0;
      chk("R1", "reset clears latch", 32'(shutdown), 0);
   endtask

   task automatic t_limits();
      do_reset();
      restart_s5 = 1'b1;
      pulse(4'b1111, 4'b0000, 4'b0000);
      chk("R6", "4 faults in restart context", 32'(shutdown), 1);
      do_reset();
      pulse(4'b0011, 4'b0000, 4'b1100);
      chk("R6", "4 faults normal context", 32'(shutdown), 0);
      chk("R6", "all disabled", 32'(fault_dis), 32'hf);
      wait_n(STEP);
      chk("R8", "reg0 back after step", 32'(fault_dis), 32'he);
      pulse(4'b0001, 4'b0000, 4'b0000);
      chk("R6", "fifth fault stops", 32'(shutdown), 1);
   endtask

   task automatic t_cascade();
      do_reset();
      dep_map[2*N+0] = 1'b1;
      dep_map[3*N+2] = 1'b1;
      restart_s5 = 1'b1;
      pulse(4'b0001, 4'b0000, 4'b0000);
      chk("R5", "feeder off", 32'(fault_dis), 32'h1);
      wait_n(1);
      chk("R5", "first downstream off", 32'(fault_dis), 32'h5);
      wait_n(1);
      chk("R5", "second downstream off", 32'(fault_dis), 32'hd);
      chk("R5", "three counted, below 4", 32'(shutdown), 0);
      pulse(4'b0010, 4'b0000, 4'b0000);
      chk("R5", "cascade counted, fourth stops", 32'(shutdown), 1);
   endtask

   task automatic t_held();
      do_reset();
      uv_flag = 4'b0010;
      wait_n(20);
      chk("R9", "held flag one disable", 32'(fault_dis), 32'h2);
      chk("R9", "held flag not recounted", 32'(shutdown), 0);
      uv_flag = 4'b1111;
      wait_n(1);
      uv_flag = '0;
      chk("R9", "count is 4 after three more", 32'(shutdown), 0);
      chk("R9", "all disabled", 32'(fault_dis), 32'hf);
   endtask

   task automatic t_order();
      do_reset();
      pulse(4'b0101, 4'b0000, 4'b0000);
      wait_n(STEP - 1);
      chk("R8", "not yet restarted", 32'(fault_dis), 32'h5);
      chk("R8", "no request yet", 32'(restart_req), 0);
      wait_n(1);
      chk("R8", "lowest first", 32'(fault_dis), 32'h4);
      chk("R8", "request reg0", 32'(restart_req), 32'h1);
      wait_n(1);
      chk("R8", "request one cycle", 32'(restart_req), 0);
      wait_n(STEP - 2);
      chk("R8", "reg2 still off", 32'(fault_dis), 32'h4);
      wait_n(1);
      chk("R8", "reg2 restarted", 32'(fault_dis), 32'h0);
      chk("R8", "request reg2", 32'(restart_req), 32'h4);
   endtask

   // k = edge distance from the fourth fault to the fifth
   task automatic t_quiet(input int k, input logic exp_stop);
      do_reset();
      pulse(4'b1111, 4'b0000, 4'b0000);
      wait_n(k - 1);
      chk("R7", "all regulators restarted", 32'(fault_dis), 0);
      pulse(4'b0001, 4'b0000, 4'b0000);
      chk("R7", (exp_stop ? "fault on forgiveness edge counts" : "forgiven after quiet run"),
          32'(shutdown), 32'(exp_stop));
   endtask

   initial begin
      rst = 1'b1; uv_flag = '0; ov_flag = '0; oc_flag = '0;
      dep_map = '0; restart_s5 = 1'b0; slp_s5 = 1'b1;
      t_reset();
      t_single();
      t_ov_and_s5();
      t_limits();
      t_cascade();
      t_held();
      t_order();
      t_quiet(QUIET, 1'b1);
      t_quiet(QUIET + 1, 1'b0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(150000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule